// File: doc/BRIEF.md
# Dual-Bank Serial ADC Frame Deserializer

This block turns the serial outputs of a multichannel ADC, one lane per channel, back into parallel samples. Each bank has its own bit clock, its own frame marker and a set of data lanes. The pad-level double-data-rate capture sits outside the block. In every bit-clock cycle the block therefore receives two samples per line: the one taken on the rising edge and the one taken on the falling edge. The frame marker runs at the sample rate and is high for the first half of each word. Its low-to-high step marks where a new word starts. The bit clock runs at half the bit rate, so a 14-bit word takes seven bit-clock cycles.

All lanes of a bank share one frame marker, so lanes that come from several converters on a common sample clock are treated as one simultaneous sample set. The marker step can land between two bit-clock cycles (even slot) or inside one cycle (odd slot). The block follows either case and rebuilds words from a 15-bit window.

A small state machine in each bank follows the marker. It has three states: `ST_HUNT` (no reference yet), `ST_TRACK` (a reference exists, counting good frames) and `ST_LOCKED` (the good-frame count has been reached). The transitions are:

- *first edge*: from `ST_HUNT` to `ST_TRACK` on any marker step.
- *good frame*: stay in `ST_TRACK` or `ST_LOCKED` when the step arrives in the expected cycle and slot.
- *lock reached*: from `ST_TRACK` to `ST_LOCKED` on the `LOCK_FRAMES`-th consecutive good frame.
- *slip*: to `ST_TRACK` when a step arrives in the wrong cycle or slot.
- *lost marker*: to `ST_HUNT` when the expected cycle passes with no step.

Top module: `adc_frame_deser`

## Requirements
- R1: Each bit-clock cycle shifts in the rising-edge sample first, then the falling-edge sample. A word is 14 bits, sent most significant bit first. Lane l of a bank appears at bits [14*l+13 : 14*l] of that bank's word bus.
- R2: A word boundary is where the sampled marker goes from 0 to 1. This step may fall between cycles (the rising-edge sample is the first 1) or inside a cycle (the falling-edge sample is the first 1). In both cases the word presented is the 14 bits just before the boundary.
- R3: For every good frame, the bank's valid output is high for exactly one bit-clock cycle, and all lane words of the bank update together in that cycle. At all other times the word bus holds its value.
- R4: The first marker step after reset, and the first after leaving `ST_HUNT`, produces no word. Only the frame that ends at a later expected boundary is output.
- R5: A marker step in an unexpected cycle or slot raises the misalign output for one cycle. The frame that ended there is discarded, the new boundary position is adopted, and the next frame is output normally. A one-bit slip in either direction therefore loses exactly one frame.
- R6: When no marker step arrives in the expected cycle, misalign pulses once and the bank returns to `ST_HUNT`. A frame that lacks its marker is lost together with the frame before it.
- R7: Locked rises in the same cycle as the `LOCK_FRAMES`-th consecutive valid frame after any misalign or reset. It is low whenever misalign is high. Valid and misalign are never high together.
- R8: The two banks are independent. A slip or a lost marker in one bank does not affect the words, valid, misalign or locked outputs of the other bank.
- R9: An active-high reset, synchronous to the bank's bit clock, clears that bank's words, valid, misalign and locked to 0 and puts it in `ST_HUNT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dco_a | input | 1 | Bank A bit clock |
| rst_a | input | 1 | Bank A synchronous reset, active high |
| a_fco_r | input | 1 | Bank A marker, rising-edge sample |
| a_fco_f | input | 1 | Bank A marker, falling-edge sample |
| a_dat_r | input | LANES_A | Bank A lanes, rising-edge samples |
| a_dat_f | input | LANES_A | Bank A lanes, falling-edge samples |
| a_word | output | 14*LANES_A | Bank A rebuilt words |
| a_valid | output | 1 | Bank A word strobe |
| a_misalign | output | 1 | Bank A boundary error pulse |
| a_locked | output | 1 | Bank A alignment locked |
| dco_b | input | 1 | Bank B bit clock |
| rst_b | input | 1 | Bank B synchronous reset, active high |
| b_fco_r | input | 1 | Bank B marker, rising-edge sample |
| b_fco_f | input | 1 | Bank B marker, falling-edge sample |
| b_dat_r | input | LANES_B | Bank B lanes, rising-edge samples |
| b_dat_f | input | LANES_B | Bank B lanes, falling-edge samples |
| b_word | output | 14*LANES_B | Bank B rebuilt words |
| b_valid | output | 1 | Bank B word strobe |
| b_misalign | output | 1 | Bank B boundary error pulse |
| b_locked | output | 1 | Bank B alignment locked |

## Verification
The hardest condition to reach from the ports is a boundary that moves by a single bit. Such a move shifts the marker from the even slot into the odd slot, and a second move brings it back into the next cycle. The bench's serializer model builds each bank's stream as a queue of bit slots. It inserts one extra zero slot before chosen frames, which produces both slip directions, and it sends one frame with its marker held low, which exercises the lost-marker path. Bank A receives all of these faults while bank B runs clean on a clock with a different phase. The scoreboard knows which frames must be discarded and checks the lock count again after each fault.

// File: rtl/adc_deser_pkg.sv
`timescale 1ns/1ps
package adc_deser_pkg;
    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_TRACK  = 2'd1,
        ST_LOCKED = 2'd2
    } align_state_e;
endpackage

// File: rtl/frame_tracker.sv
`timescale 1ns/1ps
module frame_tracker
    import adc_deser_pkg::*;
#(
    parameter int WORD_W      = 14,
    parameter int LOCK_FRAMES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fco_rise,
    input  logic fco_fall,
    output logic cap_en,
    output logic cap_odd,
    output logic frame_valid,
    output logic misalign,
    output logic locked
);
    localparam int SLOTS  = WORD_W / 2;
    localparam int CNT_W  = $clog2(SLOTS + 1);
    localparam int GOOD_W = $clog2(LOCK_FRAMES + 1);

    align_state_e state_q, state_d;
    logic              phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [GOOD_W-1:0] good_q;
    logic              fco_prev_q;
    logic              valid_q, mis_q;

    logic edge_even, edge_odd, edge_any, due, on_time, bad;

    // Boundary detection over the three most recent marker samples
    assign edge_even = !fco_prev_q && fco_rise;
    assign edge_odd  = !fco_rise && fco_fall;
    assign edge_any  = edge_even || edge_odd;
    assign due       = (cnt_q == CNT_W'(SLOTS - 1));
    assign on_time   = edge_any && due && (edge_odd == phase_q);

    // Next state and strobes
    always_comb begin
        state_d = state_q;
        cap_en  = 1'b0;
        bad     = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (edge_any) state_d = ST_TRACK;
            end
            ST_TRACK, ST_LOCKED: begin
                if (on_time) begin
                    cap_en = 1'b1;
                    if (state_q == ST_TRACK && good_q == GOOD_W'(LOCK_FRAMES - 1))
                        state_d = ST_LOCKED;
                end else if (edge_any) begin
                    bad     = 1'b1;
                    state_d = ST_TRACK;
                end else if (due) begin
                    bad     = 1'b1;
                    state_d = ST_HUNT;
                end
            end
            default: state_d = ST_HUNT;
        endcase
    end

    assign cap_odd = phase_q;

    // State register and bookkeeping
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_HUNT;
            phase_q    <= 1'b0;
            cnt_q      <= '0;
            good_q     <= '0;
            fco_prev_q <= 1'b0;
            valid_q    <= 1'b0;
            mis_q      <= 1'b0;
        end else begin
            state_q    <= state_d;
            fco_prev_q <= fco_fall;
            valid_q    <= cap_en;
            mis_q      <= bad;
            if (edge_any) begin
                phase_q <= edge_odd;
                cnt_q   <= '0;
            end else if (!due) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (state_q == ST_HUNT || bad)
                good_q <= '0;
            else if (cap_en && good_q != GOOD_W'(LOCK_FRAMES))
                good_q <= good_q + 1'b1;
        end
    end

    assign frame_valid = valid_q;
    assign misalign    = mis_q;
    assign locked      = (state_q == ST_LOCKED);

    a_r3_valid_single: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);
    a_r7_valid_mis_excl: assert property (@(posedge clk) disable iff (rst)
        !(valid_q && mis_q));
    a_r7_lock_with_valid: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> valid_q);
    a_r7_unlock_on_mis: assert property (@(posedge clk) disable iff (rst)
        mis_q |-> !locked);
    a_r4_hunt_silent: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HUNT) |=> !valid_q);
endmodule

// File: rtl/lane_shifter.sv
`timescale 1ns/1ps
module lane_shifter #(
    parameter int WORD_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_rise,
    input  logic              bit_fall,
    input  logic              cap_en,
    input  logic              cap_odd,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] sr_q, word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            word_q <= '0;
        end else begin
            sr_q <= {sr_q[WORD_W-3:0], bit_rise, bit_fall};
            if (cap_en)
                word_q <= cap_odd ? {sr_q[WORD_W-2:0], bit_rise} : sr_q;
        end
    end

    assign word = word_q;
endmodule

// File: rtl/bank_deser.sv
`timescale 1ns/1ps
module bank_deser #(
    parameter int LANES       = 4,
    parameter int WORD_W      = 14,
    parameter int LOCK_FRAMES = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fco_rise,
    input  logic                    fco_fall,
    input  logic [LANES-1:0]        dat_rise,
    input  logic [LANES-1:0]        dat_fall,
    output logic [LANES*WORD_W-1:0] words,
    output logic                    valid,
    output logic                    misalign,
    output logic                    locked
);
    logic cap_en, cap_odd;

    frame_tracker #(.WORD_W(WORD_W), .LOCK_FRAMES(LOCK_FRAMES)) u_track (
        .clk(clk), .rst(rst),
        .fco_rise(fco_rise), .fco_fall(fco_fall),
        .cap_en(cap_en), .cap_odd(cap_odd),
        .frame_valid(valid), .misalign(misalign), .locked(locked)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lane_shifter #(.WORD_W(WORD_W)) u_lane (
            .clk(clk), .rst(rst),
            .bit_rise(dat_rise[l]), .bit_fall(dat_fall[l]),
            .cap_en(cap_en), .cap_odd(cap_odd),
            .word(words[l*WORD_W +: WORD_W])
        );
    end

    a_r3_hold_words: assert property (@(posedge clk) disable iff (rst)
        !valid |-> $stable(words));
endmodule

// File: rtl/adc_frame_deser.sv
`timescale 1ns/1ps
module adc_frame_deser #(
    parameter int LANES_A     = 4,
    parameter int LANES_B     = 4,
    parameter int WORD_W      = 14,
    parameter int LOCK_FRAMES = 4
) (
    input  logic                      dco_a,
    input  logic                      rst_a,
    input  logic                      a_fco_r,
    input  logic                      a_fco_f,
    input  logic [LANES_A-1:0]        a_dat_r,
    input  logic [LANES_A-1:0]        a_dat_f,
    output logic [LANES_A*WORD_W-1:0] a_word,
    output logic                      a_valid,
    output logic                      a_misalign,
    output logic                      a_locked,
    input  logic                      dco_b,
    input  logic                      rst_b,
    input  logic                      b_fco_r,
    input  logic                      b_fco_f,
    input  logic [LANES_B-1:0]        b_dat_r,
    input  logic [LANES_B-1:0]        b_dat_f,
    output logic [LANES_B*WORD_W-1:0] b_word,
    output logic                      b_valid,
    output logic                      b_misalign,
    output logic                      b_locked
);
    bank_deser #(.LANES(LANES_A), .WORD_W(WORD_W), .LOCK_FRAMES(LOCK_FRAMES)) u_bank_a (
        .clk(dco_a), .rst(rst_a),
        .fco_rise(a_fco_r), .fco_fall(a_fco_f),
        .dat_rise(a_dat_r), .dat_fall(a_dat_f),
        .words(a_word), .valid(a_valid), .misalign(a_misalign), .locked(a_locked)
    );

    bank_deser #(.LANES(LANES_B), .WORD_W(WORD_W), .LOCK_FRAMES(LOCK_FRAMES)) u_bank_b (
        .clk(dco_b), .rst(rst_b),
        .fco_rise(b_fco_r), .fco_fall(b_fco_f),
        .dat_rise(b_dat_r), .dat_fall(b_dat_f),
        .words(b_word), .valid(b_valid), .misalign(b_misalign), .locked(b_locked)
    );
endmodule

// File: tb/test_adc_frame_deser.sv
`timescale 1ns/1ps
module test_adc_frame_deser;
    localparam int LA   = 4;
    localparam int LB   = 4;
    localparam int W    = 14;
    localparam int LOCK = 4;

    logic dco_a = 0, dco_b = 0, rst_a = 1, rst_b = 1;
    logic a_fco_r = 0, a_fco_f = 0, b_fco_r = 0, b_fco_f = 0;
    logic [LA-1:0] a_dat_r = '0, a_dat_f = '0;
    logic [LB-1:0] b_dat_r = '0, b_dat_f = '0;
    logic [LA*W-1:0] a_word;
    logic [LB*W-1:0] b_word;
    logic a_valid, a_misalign, a_locked, b_valid, b_misalign, b_locked;

    adc_frame_deser #(.LANES_A(LA), .LANES_B(LB), .WORD_W(W), .LOCK_FRAMES(LOCK)) i_adc_frame_deser (
        .dco_a(dco_a), .rst_a(rst_a), .a_fco_r(a_fco_r), .a_fco_f(a_fco_f),
        .a_dat_r(a_dat_r), .a_dat_f(a_dat_f), .a_word(a_word), .a_valid(a_valid),
        .a_misalign(a_misalign), .a_locked(a_locked),
        .dco_b(dco_b), .rst_b(rst_b), .b_fco_r(b_fco_r), .b_fco_f(b_fco_f),
        .b_dat_r(b_dat_r), .b_dat_f(b_dat_f), .b_word(b_word), .b_valid(b_valid),
        .b_misalign(b_misalign), .b_locked(b_locked)
    );

    always #10 dco_a = ~dco_a;
    initial begin
        #3;
        forever #10 dco_b = ~dco_b;
    end

    int checks = 0, errors = 0;
    bit go_a = 0, go_b = 0, ended = 0;
    logic [LA:0]     str_a[$];
    logic [LB:0]     str_b[$];
    logic [LA*W-1:0] exp_a[$];
    logic [LB*W-1:0] exp_b[$];
    int mis_a = 0, mis_b = 0, run_a = 0, run_b = 0;
    logic [LA*W-1:0] last_a = '0;
    logic [LB*W-1:0] last_b = '0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [W-1:0] sval(int bank, int k, int l);
        if (k == 2) return '1;
        if (k == 3) return '0;
        return W'((k * 613 + l * 4099 + bank * 211 + 5) % 16384);
    endfunction

    // Serializer model: one slot per bit, marker in the top bit
    task automatic push_a(int k, bit marker, bit expect_out);
        logic [LA*W-1:0] e;
        for (int b = 0; b < W; b++) begin
            logic [LA:0] s;
            s[LA] = marker && (b < W / 2);
            for (int l = 0; l < LA; l++) s[l] = sval(0, k, l)[W-1-b];
            str_a.push_back(s);
        end
        for (int l = 0; l < LA; l++) e[l*W +: W] = sval(0, k, l);
        if (expect_out) exp_a.push_back(e);
    endtask

    task automatic push_b(int k);
        logic [LB*W-1:0] e;
        for (int b = 0; b < W; b++) begin
            logic [LB:0] s;
            s[LB] = (b < W / 2);
            for (int l = 0; l < LB; l++) s[l] = sval(1, k, l)[W-1-b];
            str_b.push_back(s);
        end
        for (int l = 0; l < LB; l++) e[l*W +: W] = sval(1, k, l);
        if (k < 19) exp_b.push_back(e);
    endtask

    // Drivers: first slot of each pair goes to the rising-edge sample
    always @(negedge dco_a) if (go_a) begin
        logic [LA:0] s0, s1;
        s0 = (str_a.size() > 0) ? str_a.pop_front() : '0;
        s1 = (str_a.size() > 0) ? str_a.pop_front() : '0;
        a_fco_r = s0[LA]; a_dat_r = s0[LA-1:0];
        a_fco_f = s1[LA]; a_dat_f = s1[LA-1:0];
    end

    always @(negedge dco_b) if (go_b) begin
        logic [LB:0] s0, s1;
        s0 = (str_b.size() > 0) ? str_b.pop_front() : '0;
        s1 = (str_b.size() > 0) ? str_b.pop_front() : '0;
        b_fco_r = s0[LB]; b_dat_r = s0[LB-1:0];
        b_fco_f = s1[LB]; b_dat_f = s1[LB-1:0];
    end

    // Monitors / scoreboard
    always @(negedge dco_a) if (!rst_a) begin
        if (a_valid) begin
            if (exp_a.size() == 0) chk(0, "R4 R5 R6 unexpected word bank A", 64'(a_word), 0);
            else begin
                logic [LA*W-1:0] e;
                e = exp_a.pop_front();
                chk(a_word == e, "R1 R2 R3 word bank A", 64'(a_word), 64'(e));
            end
            run_a++;
            chk(a_locked == (run_a >= LOCK), "R7 lock bank A", 64'(a_locked), 64'(run_a >= LOCK));
            last_a = a_word;
        end else begin
            chk(a_word == last_a, "R3 hold bank A", 64'(a_word), 64'(last_a));
        end
        if (a_misalign) begin
            mis_a++;
            run_a = 0;
            chk(!a_locked && !a_valid, "R7 misalign state bank A", 64'({a_locked, a_valid}), 0);
        end
    end

    always @(negedge dco_b) if (!rst_b) begin
        if (b_valid) begin
            if (exp_b.size() == 0) chk(0, "R4 R8 unexpected word bank B", 64'(b_word), 0);
            else begin
                logic [LB*W-1:0] e;
                e = exp_b.pop_front();
                chk(b_word == e, "R1 R2 R8 word bank B", 64'(b_word), 64'(e));
            end
            run_b++;
            chk(b_locked == (run_b >= LOCK), "R7 R8 lock bank B", 64'(b_locked), 64'(run_b >= LOCK));
            last_b = b_word;
        end else begin
            chk(b_word == last_b, "R3 hold bank B", 64'(b_word), 64'(last_b));
        end
        if (b_misalign) begin
            mis_b++;
            run_b = 0;
        end
    end

    initial begin
        for (int k = 0; k <= 48; k++) begin
            if (k == 12 || k == 24) str_a.push_back('0); // one-bit slip
            push_a(k, k != 36, k < 48 && k != 11 && k != 23 && k != 35 && k != 36);
        end
        for (int k = 0; k < 20; k++) push_b(k);

        repeat (5) @(negedge dco_a);
        chk(a_word == 0 && !a_valid && !a_misalign && !a_locked, "R9 reset bank A",
            64'({a_valid, a_misalign, a_locked}), 0);
        chk(b_word == 0 && !b_valid && !b_misalign && !b_locked, "R9 reset bank B",
            64'({b_valid, b_misalign, b_locked}), 0);
        rst_a = 0; go_a = 1;
        @(negedge dco_b);
        rst_b = 0; go_b = 1;

        wait (str_a.size() == 0 && str_b.size() == 0);
        repeat (30) @(negedge dco_a);
        chk(exp_a.size() == 0, "R4 R5 R6 all words seen bank A", 64'(exp_a.size()), 0);
        chk(exp_b.size() == 0, "R8 all words seen bank B", 64'(exp_b.size()), 0);
        chk(mis_a == 4, "R5 R6 misalign count bank A", 64'(mis_a), 4);
        chk(mis_b == 1, "R8 misalign count bank B", 64'(mis_b), 1);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge dco_a);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end
endmodule